// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Unit

This block keeps the two 16-bit words a numeric coprocessor uses to talk to its host about modes and errors: a control word and a status word. The execution datapath reports exceptions as one-cycle strobes (precision, underflow, overflow, zero-divide, denormal, invalid). The block records them as sticky flags. It weighs each flag against the matching mask bit in the control word, forms an error summary, and raises an interrupt request toward the host while any unmasked flag is set.

The control word also carries the rounding, precision and infinity mode fields. The block decodes these into signals the datapath uses directly, and a reserved precision encoding falls back to extended precision. The status word also holds the busy bit, four condition-code bits and a 3-bit top-of-stack pointer. The busy bit comes from a two-state machine. In state `BUSY_IDLE`, the START transition (an `op_start` pulse) moves it to `BUSY_EXEC`. In state `BUSY_EXEC`, the FINISH transition (an `op_done` pulse) moves it back to `BUSY_IDLE`. Any other input leaves the state unchanged.

Top module: `fpu_exc_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control word becomes 0x033F (all six masks set, precision 11, rounding 00, infinity 0), the status word becomes 0x0000, and `irq_req` and `busy` are 0.
- R2: A `cw_load` pulse stores `cw_wdata` in the control word at the next edge. The stored fields are infinity at bit 12, rounding at bits 11:10, precision at bits 9:8 and masks at bits 5:0. All other bits read back as 0 on `cw_rdata`.
- R3: Bit i of `exc_event` sets status bit i. Bit 0 is invalid, 1 is denormal, 2 is zero-divide, 3 is overflow, 4 is underflow and 5 is precision. A set flag stays set until a clear or a reset.
- R4: `exc_clear` clears all six flags at the next edge. An event strobe arriving in the same cycle as the clear still sets its flag.
- R5: Status bit 7 (the error summary) is 1 exactly when some flag i is set while control-word mask bit i is 0. `irq_req` equals the error summary.
- R6: `rnd_mode` gives the rounding field: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R7: `prec_mode` gives the precision field: 00 single, 10 double, 11 extended. The reserved code 01 is kept in the control word but drives 11 on `prec_mode`.
- R8: `inf_affine` is 1 for affine (signed) infinity and 0 for projective (unsigned) infinity, following control-word bit 12.
- R9: Status bit 15 and `busy` go to 1 at the edge after `op_start` in `BUSY_IDLE`, and go to 0 at the edge after `op_done` in `BUSY_EXEC`.
- R10: `cc_load` writes `cc_wdata` {C3,C2,C1,C0} into status bits 14, 10, 9 and 8. `top_load` writes `top_wdata` into status bits 13:11. Status bit 6 always reads 0.
- R11: Loading a new mask recomputes the error summary from the flags already held, so unmasking a pending flag raises `irq_req` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cw_load | input | 1 | Write strobe for the control word |
| cw_wdata | input | 16 | New control-word value |
| exc_event | input | 6 | Exception event strobes, one bit per flag |
| exc_clear | input | 1 | Clear all exception flags |
| op_start | input | 1 | An instruction begins executing |
| op_done | input | 1 | The executing instruction has finished |
| cc_load | input | 1 | Write strobe for the condition codes |
| cc_wdata | input | 4 | Condition codes {C3,C2,C1,C0} |
| top_load | input | 1 | Write strobe for the top-of-stack field |
| top_wdata | input | 3 | New top-of-stack value |
| cw_rdata | output | 16 | Control-word readback |
| sw_rdata | output | 16 | Status-word readback |
| irq_req | output | 1 | Interrupt request toward the host |
| busy | output | 1 | Instruction in progress |
| rnd_mode | output | 2 | Decoded rounding mode |
| prec_mode | output | 2 | Effective precision |
| inf_affine | output | 1 | Affine infinity selected |

## Verification
Random cycles mix sparse exception strobes, occasional control-word loads with random masks and modes, and start/done pulses. These cycles show whether flags accumulate and whether the summary follows the changing mask pattern, rather than a latched one. Directed cases cover three things. Masks set on every flag must never raise the interrupt. A clear in the same cycle as a new strobe separates "clear wins" from "the event survives". Loading the reserved precision code shows the readback keeping 01 while the decoded mode reports extended.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
    localparam int WORD_W    = 16;
    localparam int NUM_EXC   = 6;
    localparam int CW_PC_LSB = 8;
    localparam int CW_RC_LSB = 10;
    localparam int CW_IC_BIT = 12;
    localparam int SW_ES_BIT = 7;
    localparam logic [WORD_W-1:0] CW_KEEP = 16'h1F3F;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_DOWN    = 2'b01,
        RND_UP      = 2'b10,
        RND_ZERO    = 2'b11
    } rnd_mode_e;

    typedef enum logic [1:0] {
        PREC_SINGLE = 2'b00,
        PREC_RSVD   = 2'b01,
        PREC_DOUBLE = 2'b10,
        PREC_EXT    = 2'b11
    } prec_mode_e;

    typedef enum logic {
        BUSY_IDLE = 1'b0,
        BUSY_EXEC = 1'b1
    } busy_state_e;

    typedef struct packed {
        logic               inf_affine;
        rnd_mode_e          rnd;
        prec_mode_e         prec;
        logic [NUM_EXC-1:0] mask;
    } cw_fields_t;
endpackage

// File: rtl/fpsc_ctrl_reg.sv
module fpsc_ctrl_reg
    import fpsc_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = NUM_EXC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cw_word,
    output logic [N-1:0] mask,
    output rnd_mode_e    rnd_mode,
    output prec_mode_e   prec_eff,
    output logic         inf_affine
);
    localparam int GAP_LO = CW_PC_LSB - N;
    localparam int GAP_HI = W - CW_IC_BIT - 1;

    cw_fields_t cw_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw_q.inf_affine <= 1'b0;
            cw_q.rnd        <= RND_NEAREST;
            cw_q.prec       <= PREC_EXT;
            cw_q.mask       <= '1;
        end else if (load) begin
            cw_q.inf_affine <= wdata[CW_IC_BIT];
            cw_q.rnd        <= rnd_mode_e'(wdata[CW_RC_LSB +: 2]);
            cw_q.prec       <= prec_mode_e'(wdata[CW_PC_LSB +: 2]);
            cw_q.mask       <= wdata[N-1:0];
        end
    end

    always_comb begin
        unique case (cw_q.prec)
            PREC_SINGLE: prec_eff = PREC_SINGLE;
            PREC_RSVD:   prec_eff = PREC_EXT;
            PREC_DOUBLE: prec_eff = PREC_DOUBLE;
            PREC_EXT:    prec_eff = PREC_EXT;
            default:     prec_eff = PREC_EXT;
        endcase
    end

    assign cw_word    = {{GAP_HI{1'b0}}, cw_q.inf_affine, cw_q.rnd, cw_q.prec,
                         {GAP_LO{1'b0}}, cw_q.mask};
    assign mask       = cw_q.mask;
    assign rnd_mode   = cw_q.rnd;
    assign inf_affine = cw_q.inf_affine;

    // R2
    cw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cw_word == ($past(wdata) & CW_KEEP)));

    // R7
    prec_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_word[CW_PC_LSB +: 2] == 2'b01) |-> (prec_eff == PREC_EXT));
endmodule

// File: rtl/fpsc_exc_flags.sv
module fpsc_exc_flags
    import fpsc_pkg::*;
#(
    parameter int N = NUM_EXC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] event_in,
    input  logic         clear,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         summary
);
    logic [N-1:0] flags_q;
    logic [N-1:0] live;

    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (clear)
            flags_q <= event_in;
        else
            flags_q <= flags_q | event_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_live
        assign live[i] = flags_q[i] & ~mask[i];
    end

    assign flags   = flags_q;
    assign summary = |live;

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (flags_q == $past(event_in)));
endmodule

// File: rtl/fpsc_busy_fsm.sv
module fpsc_busy_fsm
    import fpsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic op_done,
    output logic busy
);
    busy_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= BUSY_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUSY_IDLE: if (op_start) state_d = BUSY_EXEC;
            BUSY_EXEC: if (op_done)  state_d = BUSY_IDLE;
            default:   state_d = BUSY_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            BUSY_EXEC: busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // R9
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUSY_IDLE && op_start) |=> busy);

    // R9
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUSY_EXEC && op_done) |=> !busy);
endmodule

// File: rtl/fpu_exc_ctl.sv
module fpu_exc_ctl
    import fpsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cw_load,
    input  logic [15:0] cw_wdata,
    input  logic [5:0]  exc_event,
    input  logic        exc_clear,
    input  logic        op_start,
    input  logic        op_done,
    input  logic        cc_load,
    input  logic [3:0]  cc_wdata,
    input  logic        top_load,
    input  logic [2:0]  top_wdata,
    output logic [15:0] cw_rdata,
    output logic [15:0] sw_rdata,
    output logic        irq_req,
    output logic        busy,
    output logic [1:0]  rnd_mode,
    output logic [1:0]  prec_mode,
    output logic        inf_affine
);
    logic [NUM_EXC-1:0] mask_w;
    logic [NUM_EXC-1:0] flags_w;
    logic               es_w;
    logic               busy_w;
    rnd_mode_e          rnd_w;
    prec_mode_e         prec_w;
    logic [3:0]         cc_q;
    logic [2:0]         top_q;

    fpsc_ctrl_reg #(.W(WORD_W), .N(NUM_EXC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cw_load),
        .wdata      (cw_wdata),
        .cw_word    (cw_rdata),
        .mask       (mask_w),
        .rnd_mode   (rnd_w),
        .prec_eff   (prec_w),
        .inf_affine (inf_affine)
    );

    fpsc_exc_flags #(.N(NUM_EXC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_in (exc_event),
        .clear    (exc_clear),
        .mask     (mask_w),
        .flags    (flags_w),
        .summary  (es_w)
    );

    fpsc_busy_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_done  (op_done),
        .busy     (busy_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q  <= '0;
            top_q <= '0;
        end else begin
            if (cc_load)  cc_q  <= cc_wdata;
            if (top_load) top_q <= top_wdata;
        end
    end

    assign sw_rdata  = {busy_w, cc_q[3], top_q, cc_q[2], cc_q[1], cc_q[0],
                        es_w, 1'b0, flags_w};
    assign irq_req   = es_w;
    assign busy      = busy_w;
    assign rnd_mode  = rnd_w;
    assign prec_mode = prec_w;

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_w) |-> !irq_req);

    // R10
    top_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_load |=> (sw_rdata[13:11] == $past(top_wdata)));
endmodule

// File: tb/fpu_exc_ctl_tb.sv
module fpu_exc_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cw_load, exc_clear, op_start, op_done, cc_load, top_load;
    logic [15:0] cw_wdata;
    logic [5:0]  exc_event;
    logic [3:0]  cc_wdata;
    logic [2:0]  top_wdata;
    logic [15:0] cw_rdata, sw_rdata;
    logic        irq_req, busy, inf_affine;
    logic [1:0]  rnd_mode, prec_mode;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_cw;
    logic [5:0]  m_flags;
    logic        m_busy;
    logic [3:0]  m_cc;
    logic [2:0]  m_top;

    always #5 clk = ~clk;

    fpu_exc_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .cw_load(cw_load), .cw_wdata(cw_wdata),
        .exc_event(exc_event), .exc_clear(exc_clear), .op_start(op_start),
        .op_done(op_done), .cc_load(cc_load), .cc_wdata(cc_wdata),
        .top_load(top_load), .top_wdata(top_wdata), .cw_rdata(cw_rdata),
        .sw_rdata(sw_rdata), .irq_req(irq_req), .busy(busy),
        .rnd_mode(rnd_mode), .prec_mode(prec_mode), .inf_affine(inf_affine)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_es();
        return |(m_flags & ~m_cw[5:0]);
    endfunction

    function automatic logic [1:0] exp_prec(input logic [1:0] pc);
        return (pc == 2'b01) ? 2'b11 : pc;
    endfunction

    task automatic idle_inputs();
        cw_load = 0; exc_clear = 0; op_start = 0; op_done = 0;
        cc_load = 0; top_load = 0; exc_event = '0;
        cw_wdata = '0; cc_wdata = '0; top_wdata = '0;
    endtask

    task automatic model_update();
        if (cw_load) m_cw = cw_wdata & 16'h1F3F;
        if (exc_clear) m_flags = exc_event;
        else           m_flags = m_flags | exc_event;
        if (!m_busy && op_start)    m_busy = 1'b1;
        else if (m_busy && op_done) m_busy = 1'b0;
        if (cc_load)  m_cc  = cc_wdata;
        if (top_load) m_top = top_wdata;
    endtask

    task automatic compare_all();
        chk("R2 control word", cw_rdata, m_cw);
        chk("R3 flags", 16'(sw_rdata[5:0]), 16'(m_flags));
        chk("R5 summary bit", 16'(sw_rdata[7]), 16'(exp_es()));
        chk("R5 irq", 16'(irq_req), 16'(exp_es()));
        chk("R9 busy", 16'(busy), 16'(m_busy));
        chk("R10 fields", 16'({sw_rdata[15:8], sw_rdata[6]}),
            16'({m_busy, m_cc[3], m_top, m_cc[2:0], 1'b0}));
        chk("R6 rounding", 16'(rnd_mode), 16'(m_cw[11:10]));
        chk("R7 precision", 16'(prec_mode), 16'(exp_prec(m_cw[9:8])));
        chk("R8 infinity", 16'(inf_affine), 16'(m_cw[12]));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 cw reset", cw_rdata, 16'h033F);
        chk("R1 sw reset", sw_rdata, 16'h0000);
        chk("R1 irq reset", 16'(irq_req), 16'h0);
        chk("R1 busy reset", 16'(busy), 16'h0);
        chk("R1 prec reset", 16'(prec_mode), 16'h3);
        m_cw = 16'h033F; m_flags = '0; m_busy = 0; m_cc = '0; m_top = '0;
        rst_n = 1'b1;

        // R5: all masks set, every flag pending, still quiet
        exc_event = 6'h3F; step();
        chk("R5 masked quiet", 16'(irq_req), 16'h0);

        // R4: clear together with a new strobe keeps the new event
        exc_clear = 1; exc_event = 6'h04; step();
        chk("R4 clear with event", 16'(sw_rdata[5:0]), 16'h0004);
        exc_clear = 1; step();
        chk("R4 clear alone", 16'(sw_rdata[5:0]), 16'h0000);

        // R11: unmask a pending overflow
        exc_event = 6'h08; step();
        chk("R11 still masked", 16'(irq_req), 16'h0);
        cw_load = 1; cw_wdata = 16'h0337; step();
        chk("R11 unmask raises irq", 16'(irq_req), 16'h1);
        chk("R11 summary bit", 16'(sw_rdata[7]), 16'h1);

        // R7: reserved precision code held, decoded as extended
        cw_load = 1; cw_wdata = 16'hF13F; step();
        chk("R7 reserved kept", 16'(cw_rdata[9:8]), 16'h1);
        chk("R7 reserved decodes extended", 16'(prec_mode), 16'h3);
        chk("R2 unused bits zero", cw_rdata & 16'hE0C0, 16'h0000);

        // R9: start then done
        op_start = 1; step();
        chk("R9 busy after start", 16'(sw_rdata[15]), 16'h1);
        op_done = 1; step();
        chk("R9 idle after done", 16'(sw_rdata[15]), 16'h0);

        // R10: condition codes and stack pointer placement
        cc_load = 1; cc_wdata = 4'b1010; top_load = 1; top_wdata = 3'd5; step();
        chk("R10 status layout", sw_rdata & 16'h7F00, 16'h6A00);

        for (int k = 0; k < 400; k++) begin
            cw_load   = ($urandom_range(0, 7) == 0);
            cw_wdata  = 16'($urandom());
            exc_event = 6'($urandom() & $urandom() & $urandom());
            exc_clear = ($urandom_range(0, 15) == 0);
            op_start  = ($urandom_range(0, 3) == 0);
            op_done   = ($urandom_range(0, 3) == 0);
            cc_load   = ($urandom_range(0, 7) == 0);
            cc_wdata  = 4'($urandom());
            top_load  = ($urandom_range(0, 7) == 0);
            top_wdata = 3'($urandom());
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule